// File: doc/BRIEF.md
# Banked Register File Data Memory

This block is the 128-byte internal data store of a small 8-bit controller. The lowest 32 bytes also serve as four banks of eight working registers. One storage array answers to three routes. A register operand is a 3-bit number that is combined with the active bank. A direct operand is a 7-bit address. The third route is a last-in, first-out stack that lives in the same bytes. Because the routes share one array, a byte written by one route is seen by the others.

Each command is presented for one clock cycle. The block accepts a command on every cycle in which `cmd_valid` is high. A move copies a source byte into a destination and leaves the source as it was. A push moves the stack pointer up and then stores a byte. A pop reads the byte at the stack pointer, stores it, and then moves the pointer down. A bank command loads the 2-bit bank select. On the cycle after a command, `done` is high and `rd_data` holds the byte that the command moved. A move with a "none" destination is therefore a plain read. The active bank and the stack pointer are outputs.

Top module: `bank_dmem`

## Requirements
- R1: After reset, `stack_ptr` is 7'h07, `bank_sel` is 0 and `done` is 0. The reset is asynchronous active-low, and its release takes effect two clock edges after `rst_n` rises.
- R2: The operand kind (`*_kind`) has three codes. Code 0 is a register operand, with the register number in `sel[2:0]` and a physical address of bank*8 + register. Code 1 is a direct operand, with the address in `sel[6:0]`. A byte written through either route is returned by a later read through the other route at the same physical address.
- R3: A move (`cmd_op` = 0) writes the source byte to the destination and leaves the source byte unchanged.
- R4: Operand kind 2 or 3 has two meanings. As a source, it selects `imm_data`. As a destination, it means no write is made, so the move is a pure read.
- R5: A push (`cmd_op` = 1) sets the stack pointer to SP+1 and writes the source byte at the new SP. A pop (`cmd_op` = 2) copies the byte at SP to the destination and then sets SP-1. Pushed bytes return in reverse order.
- R6: The stack pointer wraps modulo 128. A push at 7'h7F gives 7'h00, and a pop at 7'h00 gives 7'h7F.
- R7: A bank command (`cmd_op` = 3) loads `bank_sel` from `dst_sel[1:0]`. The new bank applies to register operands from the next command on. Bytes held in other banks are not disturbed.
- R8: `done` is high for exactly the cycle that follows each accepted command and is low otherwise. In that cycle, `rd_data` is the byte moved, pushed or popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 move, 1 push, 2 pop, 3 set bank |
| dst_kind | input | 2 | Destination kind: 0 register, 1 direct, 2/3 none |
| dst_sel | input | 7 | Destination register number or address; bank value for a bank command |
| src_kind | input | 2 | Source kind: 0 register, 1 direct, 2/3 immediate |
| src_sel | input | 7 | Source register number or address |
| imm_data | input | 8 | Immediate source byte |
| rd_data | output | 8 | Byte moved by the previous command |
| done | output | 1 | Previous cycle held an accepted command |
| bank_sel | output | 2 | Active register bank |
| stack_ptr | output | 7 | Stack pointer |

## Verification
A wrong bank register or a wrong address join sends a register access to the wrong byte. That error shows on the next read through the direct route, one command later, as a wrong `rd_data`. A stack pointer that steps the wrong way or does not wrap appears on `stack_ptr` in the cycle after the push or pop. It also shows up as out-of-order bytes when the stack is popped. A lost write or an overwritten source appears only when that byte is next read back. The bench therefore follows each write with reads through both routes.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [1:0] {
    OP_MOVE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BANK = 2'd3
  } dmem_op_e;

  localparam logic [1:0] KIND_REG = 2'd0;
  localparam logic [1:0] KIND_DIR = 2'd1;
endpackage

// File: rtl/dmem_addr_map.sv
module dmem_addr_map #(
  parameter int ADDR_W = 7,
  parameter int REG_W  = 3,
  parameter int BANK_W = 2
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] sel,
  input  logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output logic              is_mem
);
  import dmem_pkg::*;
  localparam int PAD_W = ADDR_W - REG_W - BANK_W;

  always_comb begin
    is_mem = (kind == KIND_REG) || (kind == KIND_DIR);
    if (kind == KIND_REG) addr = {{PAD_W{1'b0}}, bank, sel[REG_W-1:0]};
    else                  addr = sel;
  end

  // R2
  always_comb begin
    if (kind == KIND_REG) begin
      reg_in_banks_chk: assert (addr < ADDR_W'(1 << (REG_W + BANK_W)));
    end
  end
endmodule

// File: rtl/dmem_array.sv
module dmem_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/dmem_ctrl.sv
module dmem_ctrl #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2,
  parameter logic [ADDR_W-1:0] SP_RESET = 7'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] dst_sel,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              dst_mem,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              src_mem,
  input  logic [DATA_W-1:0] imm_data,
  input  logic [DATA_W-1:0] mem_rd,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [BANK_W-1:0] bank_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic [DATA_W-1:0] rd_q,
  output logic              done_q
);
  import dmem_pkg::*;

  dmem_op_e          op;
  logic [ADDR_W-1:0] sp_d, sp_inc, sp_dec;
  logic [BANK_W-1:0] bank_d;
  logic [DATA_W-1:0] byte_sel;
  logic              sp_en, bank_en;

  always_comb begin
    op      = dmem_op_e'(cmd_op);
    sp_inc  = sp_q + ADDR_W'(1);
    sp_dec  = sp_q - ADDR_W'(1);
    rd_addr = (op == OP_POP) ? sp_q : src_addr;
    byte_sel = (op != OP_POP && !src_mem) ? imm_data : mem_rd;
    wr_data = byte_sel;
    wr_en   = 1'b0;
    wr_addr = dst_addr;
    sp_en   = 1'b0;
    sp_d    = sp_q;
    bank_en = 1'b0;
    bank_d  = dst_sel[BANK_W-1:0];
    if (cmd_valid) begin
      unique case (op)
        OP_MOVE: wr_en = dst_mem;
        OP_PUSH: begin
          wr_en   = 1'b1;
          wr_addr = sp_inc;
          sp_en   = 1'b1;
          sp_d    = sp_inc;
        end
        OP_POP: begin
          wr_en = dst_mem;
          sp_en = 1'b1;
          sp_d  = sp_dec;
        end
        OP_BANK: bank_en = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= SP_RESET;
      bank_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (sp_en)   sp_q   <= sp_d;
      if (bank_en) bank_q <= bank_d;
      done_q <= cmd_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd_valid) rd_q <= byte_sel;
  end

  // R8
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done_q);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !done_q);
  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == 2'd3) |=> $stable(bank_q));
  // R6
  sp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2 && sp_q == '0) |=> (sp_q == '1));
  // R5
  push_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1) |-> (wr_en && wr_addr == sp_inc));
endmodule

// File: rtl/bank_dmem.sv
module bank_dmem #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int REG_W  = 3,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        dst_kind,
  input  logic [ADDR_W-1:0] dst_sel,
  input  logic [1:0]        src_kind,
  input  logic [ADDR_W-1:0] src_sel,
  input  logic [DATA_W-1:0] imm_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [BANK_W-1:0] bank_sel,
  output logic [ADDR_W-1:0] stack_ptr
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [ADDR_W-1:0] dst_addr, src_addr, rd_addr, wr_addr;
  logic              dst_mem, src_mem, wr_en;
  logic [DATA_W-1:0] mem_rd, wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  dmem_addr_map #(.ADDR_W(ADDR_W), .REG_W(REG_W), .BANK_W(BANK_W)) u_dst_map (
    .kind(dst_kind), .sel(dst_sel), .bank(bank_sel), .addr(dst_addr), .is_mem(dst_mem));

  dmem_addr_map #(.ADDR_W(ADDR_W), .REG_W(REG_W), .BANK_W(BANK_W)) u_src_map (
    .kind(src_kind), .sel(src_sel), .bank(bank_sel), .addr(src_addr), .is_mem(src_mem));

  dmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(mem_rd));

  dmem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .dst_sel(dst_sel), .dst_addr(dst_addr), .dst_mem(dst_mem),
    .src_addr(src_addr), .src_mem(src_mem), .imm_data(imm_data),
    .mem_rd(mem_rd), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank_q(bank_sel), .sp_q(stack_ptr),
    .rd_q(rd_data), .done_q(done));
endmodule

// File: tb/sim_bank_dmem.sv
`timescale 1ns/1ps
module sim_bank_dmem;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [1:0] cmd_op, dst_kind, src_kind;
  logic [6:0] dst_sel, src_sel;
  logic [7:0] imm_data;
  logic [7:0] rd_data;
  logic       done;
  logic [1:0] bank_sel;
  logic [6:0] stack_ptr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bank_dmem u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue one command; return after the following negedge with outputs valid
  task automatic issue(input logic [1:0] op, input logic [1:0] dk, input logic [6:0] ds,
                       input logic [1:0] sk, input logic [6:0] ss, input logic [7:0] im);
    cmd_valid = 1'b1; cmd_op = op; dst_kind = dk; dst_sel = ds;
    src_kind = sk; src_sel = ss; imm_data = im;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_dir(input logic [6:0] a, input string req, input int exp);
    issue(2'd0, 2'd2, 7'd0, 2'd1, a, 8'h00);
    chk(req, rd_data, exp);
  endtask

  task automatic rd_reg(input logic [2:0] r, input string req, input int exp);
    issue(2'd0, 2'd2, 7'd0, 2'd0, {4'd0, r}, 8'h00);
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 sp", stack_ptr, 7'h07);
    chk("R1 bank", bank_sel, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_routes();
    issue(2'd0, 2'd0, 7'd3, 2'd2, 7'd0, 8'h5A);        // R3 <- imm, bank 0
    chk("R8 done", done, 1);
    chk("R8 rd_data", rd_data, 8'h5A);
    @(negedge clk);
    chk("R8 done idle", done, 0);
    rd_dir(7'h03, "R2 reg->dir", 8'h5A);
    issue(2'd0, 2'd1, 7'h1A, 2'd2, 7'd0, 8'hC3);       // direct 1Ah
    issue(2'd3, 2'd0, 7'd3, 2'd0, 7'd0, 8'h00);        // bank 3
    chk("R7 bank", bank_sel, 3);
    rd_reg(3'd2, "R2 dir->reg", 8'hC3);
  endtask

  task automatic t_move();
    issue(2'd0, 2'd1, 7'h40, 2'd2, 7'd0, 8'h77);
    issue(2'd0, 2'd1, 7'h7C, 2'd1, 7'h40, 8'h00);      // 7Ch <- 40h
    chk("R3 move rd", rd_data, 8'h77);
    rd_dir(7'h7C, "R3 dst", 8'h77);
    rd_dir(7'h40, "R3 src kept", 8'h77);
    issue(2'd0, 2'd2, 7'h40, 2'd2, 7'd0, 8'h11);       // none destination
    rd_dir(7'h40, "R4 no write", 8'h77);
  endtask

  task automatic t_banks();
    for (int b = 0; b < 4; b++) begin
      issue(2'd3, 2'd0, 7'(b), 2'd0, 7'd0, 8'h00);
      issue(2'd0, 2'd0, 7'd0, 2'd2, 7'd0, 8'(8'hA0 + b));
    end
    for (int b = 0; b < 4; b++) begin
      issue(2'd3, 2'd0, 7'(b), 2'd0, 7'd0, 8'h00);
      rd_reg(3'd0, "R7 bank keep", 8'hA0 + b);
      rd_dir(7'(b * 8), "R7 bank addr", 8'hA0 + b);
    end
    issue(2'd3, 2'd0, 7'd0, 2'd0, 7'd0, 8'h00);
  endtask

  task automatic t_stack();
    issue(2'd1, 2'd2, 7'd0, 2'd2, 7'd0, 8'h31);
    chk("R5 sp push", stack_ptr, 7'h08);
    rd_dir(7'h08, "R5 push addr", 8'h31);
    issue(2'd1, 2'd2, 7'd0, 2'd2, 7'd0, 8'h32);
    issue(2'd1, 2'd2, 7'd0, 2'd2, 7'd0, 8'h33);
    chk("R5 sp 3", stack_ptr, 7'h0A);
    for (int i = 0; i < 3; i++) begin
      issue(2'd2, 2'd1, 7'h50, 2'd0, 7'd0, 8'h00);
      chk("R5 pop rd", rd_data, 8'h33 - i);
      rd_dir(7'h50, "R5 pop dst", 8'h33 - i);
    end
    chk("R5 sp back", stack_ptr, 7'h07);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 8; i++) issue(2'd2, 2'd2, 7'd0, 2'd0, 7'd0, 8'h00);
    chk("R6 pop wrap", stack_ptr, 7'h7F);
    issue(2'd1, 2'd2, 7'd0, 2'd2, 7'd0, 8'h9E);
    chk("R6 push wrap", stack_ptr, 7'h00);
    rd_dir(7'h00, "R6 wrap addr", 8'h9E);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; dst_kind = 2'd0;
    dst_sel = 7'd0; src_kind = 2'd0; src_sel = 7'd0; imm_data = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_routes();
    t_move();
    t_banks();
    t_stack();
    t_wrap();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule